// File: doc/BRIEF.md
# Sound FIFO DMA Request Scheduler

This block decides when each of a set of DMA channels may begin a transfer. It keeps a small piece of state per channel: an active bit, a start-up countdown, and a flag that marks a channel armed by the audio path. Channels are armed in one of two ways. A general start strobe arms them. A refill event from one of two audio sample FIFOs also arms them, provided that FIFO has drained far enough. Every armed channel waits through a short start-up countdown. After that it competes for a single grant. The grant is withheld while the processor is halted and while an earlier transfer is still outstanding.

The external transfer engine reports completion with a strobe. The scheduler then retires the channel and emits single-cycle set pulses, which are meant for a sticky interrupt flag register kept outside this block. A grant to a channel that was armed by the audio path also carries override fields. These fields tell the engine to move a fixed burst of 32-bit words to a destination address that does not change.

Top module: `snd_dma_sched`

## Requirements
- R1: A refill event on a FIFO arms its channel only when the accompanying fill level (the level left after the sample read) is 16 or less. At 17 or more, nothing changes.
- R2: FIFO 0 arms channel 1 and FIFO 1 arms channel 2. The target channel must be enabled, and its 2-bit timing field (bits [2c+1:2c] of `ch_timing` for channel c) must hold code 3.
- R3: A grant to a FIFO-armed channel reports `grant_forced`=1, `grant_dst_mode`=2 (fixed destination), `grant_word32`=1 and `grant_len`=4. A grant to a channel armed by `ch_start` reports all four fields as 0.
- R4: Arming loads a countdown of 2, which drops by one on each clock edge while it is non-zero. If the arming edge is E0, the grant cannot appear before edge E2 and is visible right after E2 when nothing else blocks it.
- R5: No grant is issued while `cpu_halted` is 1. The countdown keeps running during the halt, so a ready channel is granted as soon as the halt is released.
- R6: At most one grant bit is set in any cycle. When several channels are ready, the lowest-numbered one wins.
- R7: After a grant, no further grant is issued until `xfer_done` arrives. That strobe retires the granted channel. A `xfer_done` that arrives with nothing outstanding has no effect.
- R8: On the edge where `xfer_done` retires channel c, bit c of `irq_dma_set` pulses high for one cycle if `ch_irq_en[c]` is 1. Otherwise no bit pulses.
- R9: When the highest channel (channel 3) is retired while `ch_drq_en[3]` is 1, `irq_cart_set` pulses high for one cycle.
- R10: An arming request to a channel that is already active is ignored. It neither restarts the countdown nor changes the forced flag.
- R11: After reset, no channel is active, and `grant`, `grant_forced`, `irq_dma_set` and `irq_cart_set` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_halted | input | 1 | Processor halted; blocks all grants |
| ch_enable | input | NUM_CH | Per-channel enable |
| ch_timing | input | NUM_CH*2 | Per-channel timing field; code 3 selects audio refill |
| ch_irq_en | input | NUM_CH | Per-channel completion interrupt enable |
| ch_drq_en | input | NUM_CH | Per-channel external request enable (used on the top channel) |
| ch_start | input | NUM_CH | General arming strobe (takes effect if the channel is enabled) |
| fifo_refill | input | NUM_FIFO | Refill event, one per FIFO |
| fifo_level | input | NUM_FIFO*LVL_W | Fill level left after the read, per FIFO |
| xfer_done | input | 1 | Completion strobe from the transfer engine |
| grant | output | NUM_CH | One-hot grant, visible while the channel is chosen |
| grant_forced | output | 1 | Granted channel was armed by the audio path |
| grant_dst_mode | output | 2 | Destination mode override (2 = fixed) |
| grant_word32 | output | 1 | 32-bit unit override |
| grant_len | output | LEN_W | Burst length override |
| irq_dma_set | output | NUM_CH | Single-cycle interrupt flag set pulses |
| irq_cart_set | output | 1 | Single-cycle external-request interrupt set pulse |

## Verification
The assertions take for granted that the engine raises `xfer_done` only while a grant is outstanding. They also take for granted that `xfer_done` is a single-cycle strobe. Under those two conditions, the interrupt pulses can never fall on consecutive cycles, and the counter-hold checks stay valid. The bench drives `xfer_done` for exactly one cycle, and always after the grant has been seen. There is one exception: a deliberate strobe while the block is idle, which checks that the block ignores it. All stimulus changes on the falling clock edge, so each arming request is sampled at a single, known rising edge.

// File: rtl/snd_dma_pkg.sv
package snd_dma_pkg;
   localparam int unsigned TMODE_W = 2;
   typedef logic [TMODE_W-1:0] tmode_t;
   localparam tmode_t TMODE_SOUND = 2'd3;

   typedef enum logic [1:0] {
      DST_INCR  = 2'd0,
      DST_DECR  = 2'd1,
      DST_FIXED = 2'd2,
      DST_RELD  = 2'd3
   } dst_mode_e;

   typedef struct packed {
      logic active;
      logic forced;
      logic ready;
   } ch_stat_t;
endpackage

// File: rtl/snd_dma_chan.sv
module snd_dma_chan import snd_dma_pkg::*; #(
   parameter int unsigned WAIT_INIT = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     arm_snd,
   input  logic     arm_gen,
   input  logic     clr,
   output ch_stat_t stat
);
   localparam int unsigned WAIT_W = (WAIT_INIT < 1) ? 1 : $clog2(WAIT_INIT + 1);

   logic              active_q;
   logic              forced_q;
   logic [WAIT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         forced_q <= 1'b0;
         cnt_q    <= '0;
      end else if (clr) begin
         active_q <= 1'b0;
         forced_q <= 1'b0;
         cnt_q    <= '0;
      end else if (!active_q && (arm_snd || arm_gen)) begin
         active_q <= 1'b1;
         forced_q <= arm_snd;
         cnt_q    <= WAIT_W'(WAIT_INIT);
      end else if (active_q && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   always_comb begin
      stat.active = active_q;
      stat.forced = forced_q;
      stat.ready  = active_q && (cnt_q == '0);
   end

   // R4: arming loads the start-up countdown
   a_r4_arm_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && (arm_snd || arm_gen) && !clr) |=> (active_q && cnt_q == WAIT_W'(WAIT_INIT)));

   // R4: countdown steps by one per clock
   a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && cnt_q != '0 && !clr) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R10: re-arming an active channel leaves its flavour unchanged
   a_r10_rearm_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !clr) |=> (active_q && forced_q == $past(forced_q)));
endmodule

// File: rtl/snd_dma_fifo_arm.sv
module snd_dma_fifo_arm import snd_dma_pkg::*; #(
   parameter int unsigned NUM_CH   = 4,
   parameter int unsigned NUM_FIFO = 2,
   parameter int unsigned FIFO_CH0 = 1,
   parameter int unsigned LVL_W    = 6,
   parameter int unsigned THRESH   = 16
) (
   input  logic [NUM_FIFO-1:0]         refill,
   input  logic [NUM_FIFO*LVL_W-1:0]   level,
   input  logic [NUM_CH-1:0]           enable,
   input  logic [NUM_CH*TMODE_W-1:0]   timing,
   output logic [NUM_CH-1:0]           arm_snd
);
   localparam logic [LVL_W-1:0] THR = LVL_W'(THRESH);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      if (c >= FIFO_CH0 && c < FIFO_CH0 + NUM_FIFO) begin : g_snd
         localparam int unsigned F = c - FIFO_CH0;
         logic low_water;
         assign low_water  = level[F*LVL_W +: LVL_W] <= THR;
         assign arm_snd[c] = refill[F] && low_water && enable[c]
                             && (timing[c*TMODE_W +: TMODE_W] == TMODE_SOUND);
      end else begin : g_none
         assign arm_snd[c] = 1'b0;
      end
   end
endmodule

// File: rtl/snd_dma_arb.sv
module snd_dma_arb #(
   parameter int unsigned NUM_CH    = 4,
   parameter bit          LOW_FIRST = 1'b1,
   localparam int unsigned IDX_W    = (NUM_CH < 2) ? 1 : $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ready,
   input  logic              block,
   output logic [NUM_CH-1:0] grant,
   output logic [IDX_W-1:0]  grant_idx
);
   logic [NUM_CH-1:0] pick;

   if (LOW_FIRST) begin : g_low
      always_comb begin
         pick      = '0;
         grant_idx = '0;
         for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (ready[i]) begin
               pick      = '0;
               pick[i]   = 1'b1;
               grant_idx = IDX_W'(i);
            end
         end
      end
      // R6: no ready channel below the granted one
      a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (grant != '0) |-> ((ready & (grant - 1'b1)) == '0));
   end else begin : g_high
      always_comb begin
         pick      = '0;
         grant_idx = '0;
         for (int i = 0; i < NUM_CH; i++) begin
            if (ready[i]) begin
               pick      = '0;
               pick[i]   = 1'b1;
               grant_idx = IDX_W'(i);
            end
         end
      end
   end

   assign grant = block ? '0 : pick;

   // R6: one grant at most
   a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
endmodule

// File: rtl/snd_dma_done.sv
module snd_dma_done #(
   parameter int unsigned NUM_CH  = 4,
   parameter int unsigned CART_CH = 3,
   localparam int unsigned IDX_W  = (NUM_CH < 2) ? 1 : $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              grant_vld,
   input  logic [IDX_W-1:0]  grant_idx,
   input  logic              xfer_done,
   input  logic [NUM_CH-1:0] irq_en,
   input  logic [NUM_CH-1:0] drq_en,
   output logic              busy,
   output logic [NUM_CH-1:0] clr,
   output logic [NUM_CH-1:0] irq_dma_set,
   output logic              irq_cart_set
);
   logic             busy_q;
   logic [IDX_W-1:0] idx_q;
   logic             retire;
   logic [NUM_CH-1:0] idx_hot;

   assign retire = busy_q && xfer_done;
   assign busy   = busy_q;

   always_comb begin
      idx_hot = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (idx_q == IDX_W'(i)) idx_hot[i] = 1'b1;
      end
   end

   assign clr = retire ? idx_hot : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q       <= 1'b0;
         idx_q        <= '0;
         irq_dma_set  <= '0;
         irq_cart_set <= 1'b0;
      end else begin
         irq_dma_set  <= '0;
         irq_cart_set <= 1'b0;
         if (retire) begin
            busy_q       <= 1'b0;
            irq_dma_set  <= irq_en & idx_hot;
            irq_cart_set <= idx_hot[CART_CH] && drq_en[CART_CH];
         end else if (grant_vld) begin
            busy_q <= 1'b1;
            idx_q  <= grant_idx;
         end
      end
   end

   // R7: nothing is granted while a transfer is outstanding
   a_r7_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !grant_vld);

   // R8: completion flag pulses last a single cycle
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_dma_set != '0) |=> (irq_dma_set == '0));

   // R9: external-request pulse only follows a retirement
   a_r9_cart_cause: assert property (@(posedge clk) disable iff (!rst_n)
      irq_cart_set |-> ($past(xfer_done) && $past(busy_q)));
endmodule

// File: rtl/snd_dma_sched.sv
module snd_dma_sched import snd_dma_pkg::*; #(
   parameter int unsigned NUM_CH    = 4,
   parameter int unsigned NUM_FIFO  = 2,
   parameter int unsigned FIFO_CH0  = 1,
   parameter int unsigned LVL_W     = 6,
   parameter int unsigned THRESH    = 16,
   parameter int unsigned WAIT_INIT = 2,
   parameter int unsigned BURST_LEN = 4,
   parameter bit          LOW_FIRST = 1'b1,
   localparam int unsigned LEN_W    = $clog2(BURST_LEN + 1),
   localparam int unsigned IDX_W    = (NUM_CH < 2) ? 1 : $clog2(NUM_CH),
   localparam int unsigned CART_CH  = NUM_CH - 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cpu_halted,
   input  logic [NUM_CH-1:0]          ch_enable,
   input  logic [NUM_CH*TMODE_W-1:0]  ch_timing,
   input  logic [NUM_CH-1:0]          ch_irq_en,
   input  logic [NUM_CH-1:0]          ch_drq_en,
   input  logic [NUM_CH-1:0]          ch_start,
   input  logic [NUM_FIFO-1:0]        fifo_refill,
   input  logic [NUM_FIFO*LVL_W-1:0]  fifo_level,
   input  logic                       xfer_done,
   output logic [NUM_CH-1:0]          grant,
   output logic                       grant_forced,
   output logic [1:0]                 grant_dst_mode,
   output logic                       grant_word32,
   output logic [LEN_W-1:0]           grant_len,
   output logic [NUM_CH-1:0]          irq_dma_set,
   output logic                       irq_cart_set
);
   if (NUM_CH < 2) begin : g_chk_ch
      $error("snd_dma_sched: NUM_CH must be at least 2");
   end
   if (FIFO_CH0 + NUM_FIFO > NUM_CH) begin : g_chk_map
      $error("snd_dma_sched: FIFO channels exceed NUM_CH");
   end
   if (THRESH >= (1 << LVL_W)) begin : g_chk_lvl
      $error("snd_dma_sched: THRESH does not fit LVL_W");
   end
   if (BURST_LEN < 1) begin : g_chk_len
      $error("snd_dma_sched: BURST_LEN must be positive");
   end

   logic [NUM_CH-1:0] arm_snd;
   logic [NUM_CH-1:0] arm_gen;
   logic [NUM_CH-1:0] clr;
   logic [NUM_CH-1:0] ready;
   logic [NUM_CH-1:0] forced;
   logic [IDX_W-1:0]  grant_idx;
   logic              busy;

   assign arm_gen = ch_start & ch_enable;

   snd_dma_fifo_arm #(
      .NUM_CH(NUM_CH), .NUM_FIFO(NUM_FIFO), .FIFO_CH0(FIFO_CH0),
      .LVL_W(LVL_W), .THRESH(THRESH)
   ) u_arm (
      .refill(fifo_refill), .level(fifo_level), .enable(ch_enable),
      .timing(ch_timing), .arm_snd(arm_snd)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      ch_stat_t st;
      snd_dma_chan #(.WAIT_INIT(WAIT_INIT)) u_chan (
         .clk(clk), .rst_n(rst_n), .arm_snd(arm_snd[c]), .arm_gen(arm_gen[c]),
         .clr(clr[c]), .stat(st)
      );
      assign ready[c]  = st.ready;
      assign forced[c] = st.forced;
   end

   snd_dma_arb #(.NUM_CH(NUM_CH), .LOW_FIRST(LOW_FIRST)) u_arb (
      .clk(clk), .rst_n(rst_n), .ready(ready), .block(cpu_halted || busy),
      .grant(grant), .grant_idx(grant_idx)
   );

   snd_dma_done #(.NUM_CH(NUM_CH), .CART_CH(CART_CH)) u_done (
      .clk(clk), .rst_n(rst_n), .grant_vld(grant != '0), .grant_idx(grant_idx),
      .xfer_done(xfer_done), .irq_en(ch_irq_en), .drq_en(ch_drq_en),
      .busy(busy), .clr(clr), .irq_dma_set(irq_dma_set), .irq_cart_set(irq_cart_set)
   );

   assign grant_forced   = (grant & forced) != '0;
   assign grant_dst_mode = grant_forced ? DST_FIXED : 2'd0;
   assign grant_word32   = grant_forced;
   assign grant_len      = grant_forced ? LEN_W'(BURST_LEN) : '0;

   // R5: a halted processor sees no grant
   a_r5_halt_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_halted |-> (grant == '0));
endmodule

// File: tb/snd_dma_sched_bench.sv
module snd_dma_sched_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_halted = 1'b0;
   logic [3:0]  ch_enable = '0;
   logic [7:0]  ch_timing = '0;
   logic [3:0]  ch_irq_en = '0;
   logic [3:0]  ch_drq_en = '0;
   logic [3:0]  ch_start = '0;
   logic [1:0]  fifo_refill = '0;
   logic [11:0] fifo_level = '0;
   logic        xfer_done = 1'b0;
   logic [3:0]  grant;
   logic        grant_forced;
   logic [1:0]  grant_dst_mode;
   logic        grant_word32;
   logic [2:0]  grant_len;
   logic [3:0]  irq_dma_set;
   logic        irq_cart_set;

   int n_chk = 0;
   int n_bad = 0;
   bit all_done = 1'b0;

   always #10 clk = ~clk;

   snd_dma_sched u_snd_dma_sched (
      .clk(clk), .rst_n(rst_n), .cpu_halted(cpu_halted), .ch_enable(ch_enable),
      .ch_timing(ch_timing), .ch_irq_en(ch_irq_en), .ch_drq_en(ch_drq_en),
      .ch_start(ch_start), .fifo_refill(fifo_refill), .fifo_level(fifo_level),
      .xfer_done(xfer_done), .grant(grant), .grant_forced(grant_forced),
      .grant_dst_mode(grant_dst_mode), .grant_word32(grant_word32),
      .grant_len(grant_len), .irq_dma_set(irq_dma_set), .irq_cart_set(irq_cart_set)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // drive one completion strobe at the current falling edge
   task automatic finish_xfer();
      xfer_done = 1'b1;
      tick();
      xfer_done = 1'b0;
   endtask

   task automatic t_reset();
      tick();
      chk("R11 grant", grant, 0);
      chk("R11 forced", grant_forced, 0);
      chk("R11 irq", irq_dma_set, 0);
      chk("R11 cart", irq_cart_set, 0);
      xfer_done = 1'b1;            // R7: stray completion while idle
      tick();
      xfer_done = 1'b0;
      tick();
      chk("R7 idle done irq", irq_dma_set, 0);
      chk("R7 idle done cart", irq_cart_set, 0);
   endtask

   task automatic t_refill_fifo0();
      ch_enable = 4'b0110;
      ch_timing = {2'd0, 2'd3, 2'd3, 2'd0};
      ch_irq_en = 4'b0010;
      fifo_level[5:0] = 6'd16;
      fifo_refill = 2'b01;
      tick();
      fifo_refill = 2'b00;
      chk("R4 no grant after E0", grant, 0);
      tick();
      chk("R4 no grant after E1", grant, 0);
      tick();
      chk("R1 R2 grant ch1 at level 16", grant, 4'b0010);
      chk("R3 forced", grant_forced, 1);
      chk("R3 dst mode", grant_dst_mode, 2);
      chk("R3 word32", grant_word32, 1);
      chk("R3 len", grant_len, 4);
      tick();
      chk("R7 held while outstanding", grant, 0);
      finish_xfer();
      chk("R8 irq ch1", irq_dma_set, 4'b0010);
      chk("R9 no cart for ch1", irq_cart_set, 0);
      tick();
      chk("R8 pulse ends", irq_dma_set, 0);
      chk("R7 retired no regrant", grant, 0);
   endtask

   task automatic t_level_above();
      int seen = 0;
      fifo_level[5:0] = 6'd17;
      fifo_refill = 2'b01;
      tick();
      fifo_refill = 2'b00;
      for (int i = 0; i < 6; i++) begin
         if (grant != 0) seen++;
         tick();
      end
      chk("R1 level 17 ignored", seen, 0);
   endtask

   task automatic t_mode();
      int seen = 0;
      ch_timing = {2'd0, 2'd3, 2'd2, 2'd0};
      fifo_level[5:0] = 6'd4;
      fifo_refill = 2'b01;
      tick();
      fifo_refill = 2'b00;
      for (int i = 0; i < 5; i++) begin
         if (grant != 0) seen++;
         tick();
      end
      chk("R2 timing code 2 ignored", seen, 0);
      ch_timing = {2'd0, 2'd3, 2'd3, 2'd0};
      ch_enable = 4'b0100;
      fifo_refill = 2'b01;
      tick();
      fifo_refill = 2'b00;
      seen = 0;
      for (int i = 0; i < 5; i++) begin
         if (grant != 0) seen++;
         tick();
      end
      chk("R2 disabled channel ignored", seen, 0);
   endtask

   task automatic t_fifo1();
      ch_enable = 4'b0110;
      ch_irq_en = 4'b0010;
      fifo_level[11:6] = 6'd0;
      fifo_refill = 2'b10;
      tick();
      fifo_refill = 2'b00;
      tick();
      tick();
      chk("R2 fifo1 grants ch2", grant, 4'b0100);
      chk("R3 fifo1 len", grant_len, 4);
      tick();
      finish_xfer();
      chk("R8 irq disabled ch2", irq_dma_set, 0);
      tick();
   endtask

   task automatic t_halt();
      cpu_halted = 1'b1;
      fifo_level[5:0] = 6'd8;
      fifo_refill = 2'b01;
      tick();
      fifo_refill = 2'b00;
      tick();
      tick();
      chk("R5 halted E2", grant, 0);
      tick();
      chk("R5 halted E3", grant, 0);
      cpu_halted = 1'b0;
      #1;
      chk("R5 grant on release", grant, 4'b0010);
      tick();
      finish_xfer();
      tick();
   endtask

   task automatic t_priority();
      ch_enable = 4'b1001;
      ch_timing = '0;
      ch_irq_en = 4'b1000;
      ch_drq_en = 4'b1000;
      ch_start = 4'b1001;
      tick();
      ch_start = 4'b0000;
      tick();
      tick();
      chk("R6 lowest first", grant, 4'b0001);
      chk("R3 plain not forced", grant_forced, 0);
      chk("R3 plain len", grant_len, 0);
      tick();
      finish_xfer();
      chk("R8 no irq ch0", irq_dma_set, 0);
      chk("R6 next channel", grant, 4'b1000);
      tick();
      finish_xfer();
      chk("R8 irq ch3", irq_dma_set, 4'b1000);
      chk("R9 cart pulse", irq_cart_set, 1);
      tick();
      chk("R9 cart pulse ends", irq_cart_set, 0);
      ch_drq_en = 4'b0000;
   endtask

   task automatic t_rearm();
      ch_enable = 4'b0010;
      ch_timing = {2'd0, 2'd0, 2'd3, 2'd0};
      ch_start = 4'b0010;
      tick();
      ch_start = 4'b0000;
      fifo_level[5:0] = 6'd0;
      fifo_refill = 2'b01;
      tick();
      fifo_refill = 2'b00;
      chk("R10 no early grant", grant, 0);
      tick();
      chk("R10 grant keeps schedule", grant, 4'b0010);
      chk("R10 flavour unchanged", grant_forced, 0);
      tick();
      finish_xfer();
      tick();
   endtask

   initial begin
      #(20 * 20000);
      if (!all_done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      t_reset();
      t_refill_fifo0();
      t_level_above();
      t_mode();
      t_fifo1();
      t_halt();
      t_priority();
      t_rearm();
      all_done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule